// File: doc/BRIEF.md
# Two-Thread Congestion Throttle and Decode Share Unit

This block balances shared back-end resources between the two hardware threads of a simultaneous multithreading core. For each thread it watches two pressure signals that the surrounding pipeline reports as counters: outstanding second-level load misses plus outstanding translation misses, and the number of shared reorder-buffer entries the thread holds. When either signal crosses its trigger threshold, the thread enters a throttled mode. The response grows harsher the longer the congestion lasts. The thread first loses decode priority. After that its decode is stopped. Finally it receives a single flush request for its instructions still waiting for dispatch, and its decode stays blocked. The thread returns to normal only when both signals fall below a second, lower pair of thresholds.

The same block decides which thread owns the decode slot in each cycle. Software gives each thread a 3-bit priority level. The gap between the two effective levels sets a repeating pattern, driven by a modulo counter, in which the stronger thread receives all slots but one. A thread whose decode is stopped never receives a slot, and the slot passes to the other thread.

Each thread has its own state machine. Its states are NORMAL, DEPRIO (priority lowered), STALL (decode stopped), PURGE (one cycle that carries the flush request) and HOLD (decode stopped after the flush). The transitions are:
- trigger: NORMAL to DEPRIO
- escalate: DEPRIO to STALL, and STALL to PURGE
- settle: PURGE to HOLD
- release: any throttled state back to NORMAL when the clear condition holds

Top module: `thr_throttle_top`

## Requirements
- R1: During and after reset every thread is in NORMAL (level code 0), no flush is requested, and the decode-slot counter starts at 0.
- R2: A thread in NORMAL moves to DEPRIO (level code 1) one cycle after it sees either of two conditions. The first is that its L2 miss count plus its TLB miss count is at or above `miss_hi_i`. The second is that its reorder-buffer occupancy is at or above `rob_hi_i`.
- R3: The clear condition is that the miss sum is below `miss_lo_i` and the occupancy is below `rob_lo_i`. When it holds, a throttled thread returns to NORMAL on the next cycle. Between the low and high thresholds the thread keeps its current level, apart from escalation.
- R4: If the clear condition is absent, a thread that has spent `dwell_lim_i`+1 consecutive cycles in DEPRIO moves to STALL (level code 2). In the same way, one that has spent `dwell_lim_i`+1 consecutive cycles in STALL moves to PURGE (level code 3). PURGE lasts one cycle and then moves to HOLD (level code 3). HOLD is left only by clearing. No level is ever skipped.
- R5: While a thread is in DEPRIO, its effective priority level is 0 whatever its software level is.
- R6: `flush_o[t]` is high for exactly the one cycle that thread t spends in PURGE. It is high once per congestion episode and never again before the thread has returned to NORMAL.
- R7: Let the effective levels be a (thread 0) and b (thread 1), and let M = |a-b|+2. The slot counter steps by 1 each cycle modulo M. Counter values below M-1 belong to the thread with the higher level, which is thread 0 when the levels are equal. Value M-1 belongs to the other thread.
- R8: A thread in STALL, PURGE or HOLD never gets a decode grant. Its slot goes to the other thread if that thread is not blocked. If both threads are blocked, no grant is given. `grant_o` is never high for both threads at once.
- R9: A drop in M can leave the counter at or above M-1. When that happens, the cycle is treated as the last slot, and the counter returns to 0 on the next cycle.
- R10: The two threads' state machines are independent. Congestion on one thread never changes the other thread's level or flush output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| l2_miss_i | input | 2 x MISS_W | Outstanding L2 load misses per thread |
| tlb_miss_i | input | 2 x MISS_W | Outstanding TLB misses per thread |
| rob_occ_i | input | 2 x ROB_W | Reorder-buffer entries held per thread |
| pri_i | input | 2 x 3 | Software priority level per thread |
| miss_hi_i | input | MISS_W+1 | Miss-sum trigger threshold |
| miss_lo_i | input | MISS_W+1 | Miss-sum clear threshold |
| rob_hi_i | input | ROB_W | Occupancy trigger threshold |
| rob_lo_i | input | ROB_W | Occupancy clear threshold |
| dwell_lim_i | input | DWELL_W | Cycles per level, minus one, before escalation |
| grant_o | output | 2 | One-hot-or-zero decode slot grant per thread |
| flush_o | output | 2 | Single-cycle flush request per thread |
| level_o | output | 2 x 2 | Throttle level per thread (0 normal, 1 deprioritised, 2 stalled, 3 flushed) |

## Verification
The bench drives the miss and occupancy counters into the band between the clear and trigger thresholds, where a design without hysteresis would drop to NORMAL too early or re-trigger in a loop. It holds congestion long enough to walk the whole escalation path. A dwell counter that is off by one would escalate a cycle early or late, and a missing PURGE state would repeat the flush or never raise it. It moves the priority gap sharply while the slot counter is high, where a counter that only wraps on equality would run far past the new pattern length. It also blocks both threads at once and puts a deprioritised thread against a weaker software level. These cases catch a grant given to a stalled thread and a priority drop that was never applied.

// File: rtl/thr_pkg.sv
package thr_pkg;

    localparam int NUM_THR = 2;
    localparam int PRI_W   = 3;
    localparam int LVL_W   = 2;

    typedef enum logic [2:0] {
        TS_NORMAL = 3'd0,
        TS_DEPRIO = 3'd1,
        TS_STALL  = 3'd2,
        TS_PURGE  = 3'd3,
        TS_HOLD   = 3'd4
    } thr_state_e;

    localparam logic [LVL_W-1:0] LVL_NORMAL  = 2'd0;
    localparam logic [LVL_W-1:0] LVL_DEPRIO  = 2'd1;
    localparam logic [LVL_W-1:0] LVL_STALL   = 2'd2;
    localparam logic [LVL_W-1:0] LVL_FLUSHED = 2'd3;

endpackage

// File: rtl/thr_cong_detect.sv
module thr_cong_detect #(
    parameter int MISS_W = 6,
    parameter int ROB_W  = 7
) (
    input  logic [MISS_W-1:0] l2_miss_i,
    input  logic [MISS_W-1:0] tlb_miss_i,
    input  logic [ROB_W-1:0]  rob_occ_i,
    input  logic [MISS_W:0]   miss_hi_i,
    input  logic [MISS_W:0]   miss_lo_i,
    input  logic [ROB_W-1:0]  rob_hi_i,
    input  logic [ROB_W-1:0]  rob_lo_i,
    output logic              trig_o,
    output logic              clr_o
);

    logic [MISS_W:0] miss_sum;

    always_comb begin
        miss_sum = {1'b0, l2_miss_i} + {1'b0, tlb_miss_i};
        trig_o   = (miss_sum >= miss_hi_i) || (rob_occ_i >= rob_hi_i);
        clr_o    = (miss_sum <  miss_lo_i) && (rob_occ_i <  rob_lo_i);
    end

endmodule

// File: rtl/thr_level_fsm.sv
module thr_level_fsm
    import thr_pkg::*;
#(
    parameter int DWELL_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               trig_i,
    input  logic               clr_i,
    input  logic [DWELL_W-1:0] dwell_lim_i,
    input  logic [PRI_W-1:0]   pri_i,
    output logic [LVL_W-1:0]   level_o,
    output logic               flush_o,
    output logic               block_o,
    output logic [PRI_W-1:0]   eff_pri_o
);

    localparam logic [DWELL_W-1:0] DW_ONE = {{(DWELL_W-1){1'b0}}, 1'b1};

    thr_state_e         state_q, state_d;
    logic [DWELL_W-1:0] dwell_q, dwell_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= TS_NORMAL;
            dwell_q <= '0;
        end else begin
            state_q <= state_d;
            dwell_q <= dwell_d;
        end
    end

    // transitions: trigger, escalate, settle, release
    always_comb begin
        state_d = state_q;
        dwell_d = dwell_q;
        unique case (state_q)
            TS_NORMAL: begin
                dwell_d = '0;
                if (trig_i) state_d = TS_DEPRIO;
            end
            TS_DEPRIO, TS_STALL: begin
                if (clr_i) begin
                    state_d = TS_NORMAL;
                    dwell_d = '0;
                end else if (dwell_q >= dwell_lim_i) begin
                    state_d = (state_q == TS_DEPRIO) ? TS_STALL : TS_PURGE;
                    dwell_d = '0;
                end else begin
                    dwell_d = dwell_q + DW_ONE;
                end
            end
            TS_PURGE: begin
                state_d = clr_i ? TS_NORMAL : TS_HOLD;
            end
            TS_HOLD: begin
                if (clr_i) state_d = TS_NORMAL;
            end
            default: begin
                state_d = TS_NORMAL;
                dwell_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        level_o   = LVL_NORMAL;
        flush_o   = 1'b0;
        block_o   = 1'b0;
        eff_pri_o = pri_i;
        unique case (state_q)
            TS_NORMAL: level_o = LVL_NORMAL;
            TS_DEPRIO: begin
                level_o   = LVL_DEPRIO;
                eff_pri_o = '0;
            end
            TS_STALL: begin
                level_o = LVL_STALL;
                block_o = 1'b1;
            end
            TS_PURGE: begin
                level_o = LVL_FLUSHED;
                block_o = 1'b1;
                flush_o = 1'b1;
            end
            TS_HOLD: begin
                level_o = LVL_FLUSHED;
                block_o = 1'b1;
            end
            default: level_o = LVL_NORMAL;
        endcase
    end

    // R4: NORMAL can only advance to DEPRIO, never further
    p_no_skip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == TS_NORMAL) |=> (state_q == TS_NORMAL || state_q == TS_DEPRIO));

    // R4: DEPRIO never jumps straight to a flush
    p_deprio_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == TS_DEPRIO) |=> (state_q != TS_PURGE && state_q != TS_HOLD));

    // R3: clearing returns the thread to NORMAL on the next cycle
    p_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && state_q != TS_NORMAL) |=> (state_q == TS_NORMAL));

    // R6: a flush request follows a stall and never repeats back to back
    p_flush_from_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_o |-> ($past(state_q) == TS_STALL));
    p_flush_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_o |=> !flush_o);

endmodule

// File: rtl/thr_decode_share.sv
module thr_decode_share
    import thr_pkg::*;
(
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic [NUM_THR-1:0][PRI_W-1:0]   eff_pri_i,
    input  logic [NUM_THR-1:0]              block_i,
    output logic [NUM_THR-1:0]              grant_o
);

    localparam int SLOT_W = $clog2((1 << PRI_W) + 1);
    localparam logic [SLOT_W-1:0] S_ONE = {{(SLOT_W-1){1'b0}}, 1'b1};
    localparam logic [SLOT_W-1:0] S_TWO = S_ONE + S_ONE;

    logic [SLOT_W-1:0] cnt_q, cnt_d;
    logic [PRI_W-1:0]  gap;
    logic [SLOT_W-1:0] period;
    logic [SLOT_W-1:0] last_slot;
    logic              fav;
    logic              at_last;
    logic              owner;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    always_comb begin
        fav       = (eff_pri_i[1] > eff_pri_i[0]);
        gap       = fav ? (eff_pri_i[1] - eff_pri_i[0]) : (eff_pri_i[0] - eff_pri_i[1]);
        period    = {{(SLOT_W-PRI_W){1'b0}}, gap} + S_TWO;
        last_slot = period - S_ONE;
        at_last   = (cnt_q >= last_slot);
        owner     = at_last ? ~fav : fav;
        cnt_d     = at_last ? '0 : (cnt_q + S_ONE);
        grant_o   = '0;
        if (!block_i[owner])       grant_o[owner]  = 1'b1;
        else if (!block_i[~owner]) grant_o[~owner] = 1'b1;
    end

    // R8: at most one thread decodes, and never a blocked one
    p_one_grant_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant_o));
    p_blocked_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_o & block_i) == '0);

    // R7: the counter steps by one inside the pattern
    p_cnt_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q < last_slot) |=> (cnt_q == $past(cnt_q) + S_ONE));

    // R9: at or past the last slot the counter wraps to zero
    p_cnt_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q >= last_slot) |=> (cnt_q == '0));

endmodule

// File: rtl/thr_throttle_top.sv
module thr_throttle_top
    import thr_pkg::*;
#(
    parameter int MISS_W  = 6,
    parameter int ROB_W   = 7,
    parameter int DWELL_W = 8
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [NUM_THR-1:0][MISS_W-1:0] l2_miss_i,
    input  logic [NUM_THR-1:0][MISS_W-1:0] tlb_miss_i,
    input  logic [NUM_THR-1:0][ROB_W-1:0]  rob_occ_i,
    input  logic [NUM_THR-1:0][PRI_W-1:0]  pri_i,
    input  logic [MISS_W:0]               miss_hi_i,
    input  logic [MISS_W:0]               miss_lo_i,
    input  logic [ROB_W-1:0]              rob_hi_i,
    input  logic [ROB_W-1:0]              rob_lo_i,
    input  logic [DWELL_W-1:0]            dwell_lim_i,
    output logic [NUM_THR-1:0]            grant_o,
    output logic [NUM_THR-1:0]            flush_o,
    output logic [NUM_THR-1:0][LVL_W-1:0] level_o
);

    logic [NUM_THR-1:0]            trig;
    logic [NUM_THR-1:0]            clr;
    logic [NUM_THR-1:0]            block;
    logic [NUM_THR-1:0][PRI_W-1:0] eff_pri;

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        thr_cong_detect #(
            .MISS_W (MISS_W),
            .ROB_W  (ROB_W)
        ) u_detect (
            .l2_miss_i  (l2_miss_i[t]),
            .tlb_miss_i (tlb_miss_i[t]),
            .rob_occ_i  (rob_occ_i[t]),
            .miss_hi_i  (miss_hi_i),
            .miss_lo_i  (miss_lo_i),
            .rob_hi_i   (rob_hi_i),
            .rob_lo_i   (rob_lo_i),
            .trig_o     (trig[t]),
            .clr_o      (clr[t])
        );

        thr_level_fsm #(
            .DWELL_W (DWELL_W)
        ) u_fsm (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .trig_i      (trig[t]),
            .clr_i       (clr[t]),
            .dwell_lim_i (dwell_lim_i),
            .pri_i       (pri_i[t]),
            .level_o     (level_o[t]),
            .flush_o     (flush_o[t]),
            .block_o     (block[t]),
            .eff_pri_o   (eff_pri[t])
        );
    end

    thr_decode_share u_share (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .eff_pri_i (eff_pri),
        .block_i   (block),
        .grant_o   (grant_o)
    );

endmodule

// File: tb/thr_throttle_top_tb_top.sv
module thr_throttle_top_tb_top;

    localparam int MISS_W  = 6;
    localparam int ROB_W   = 7;
    localparam int DWELL_W = 8;

    logic                   clk_i = 1'b0;
    logic                   rst_ni = 1'b0;
    logic [1:0][MISS_W-1:0] l2_miss_i = '0;
    logic [1:0][MISS_W-1:0] tlb_miss_i = '0;
    logic [1:0][ROB_W-1:0]  rob_occ_i = '0;
    logic [1:0][2:0]        pri_i = '0;
    logic [MISS_W:0]        miss_hi_i = 7'd8;
    logic [MISS_W:0]        miss_lo_i = 7'd4;
    logic [ROB_W-1:0]       rob_hi_i = 7'd40;
    logic [ROB_W-1:0]       rob_lo_i = 7'd20;
    logic [DWELL_W-1:0]     dwell_lim_i = 8'd3;
    logic [1:0]             grant_o;
    logic [1:0]             flush_o;
    logic [1:0][1:0]        level_o;

    thr_throttle_top #(
        .MISS_W  (MISS_W),
        .ROB_W   (ROB_W),
        .DWELL_W (DWELL_W)
    ) dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .l2_miss_i   (l2_miss_i),
        .tlb_miss_i  (tlb_miss_i),
        .rob_occ_i   (rob_occ_i),
        .pri_i       (pri_i),
        .miss_hi_i   (miss_hi_i),
        .miss_lo_i   (miss_lo_i),
        .rob_hi_i    (rob_hi_i),
        .rob_lo_i    (rob_lo_i),
        .dwell_lim_i (dwell_lim_i),
        .grant_o     (grant_o),
        .flush_o     (flush_o),
        .level_o     (level_o)
    );

    always #10 clk_i = ~clk_i;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // reference model state
    int m_lvl[2];
    int m_dwell[2];
    bit m_flush[2];
    int m_cnt;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int eff_of(input int t);
        return (m_lvl[t] == 1) ? 0 : int'(pri_i[t]);
    endfunction

    function automatic int exp_grant();
        int a, b, per, hi, own, res;
        a   = eff_of(0);
        b   = eff_of(1);
        per = (a > b ? a - b : b - a) + 2;
        hi  = (b > a) ? 1 : 0;
        own = (m_cnt >= per - 1) ? 1 - hi : hi;
        res = 0;
        if (m_lvl[own] < 2)          res = 1 << own;
        else if (m_lvl[1 - own] < 2) res = 1 << (1 - own);
        return res;
    endfunction

    task automatic model_advance();
        int a, b, per, s;
        bit up, down;
        a   = eff_of(0);
        b   = eff_of(1);
        per = (a > b ? a - b : b - a) + 2;
        m_cnt = (m_cnt >= per - 1) ? 0 : m_cnt + 1;
        for (int t = 0; t < 2; t++) begin
            s    = int'(l2_miss_i[t]) + int'(tlb_miss_i[t]);
            up   = (s >= int'(miss_hi_i)) || (int'(rob_occ_i[t]) >= int'(rob_hi_i));
            down = (s < int'(miss_lo_i)) && (int'(rob_occ_i[t]) < int'(rob_lo_i));
            m_flush[t] = 1'b0;
            if (m_lvl[t] == 0) begin
                if (up) begin m_lvl[t] = 1; m_dwell[t] = 0; end
            end else if (down) begin
                m_lvl[t] = 0; m_dwell[t] = 0;
            end else if (m_lvl[t] < 3) begin
                if (m_dwell[t] >= int'(dwell_lim_i)) begin
                    m_lvl[t]++;
                    m_dwell[t] = 0;
                    if (m_lvl[t] == 3) m_flush[t] = 1'b1;
                end else begin
                    m_dwell[t]++;
                end
            end
        end
    endtask

    // inputs are set after a falling edge; compare, then let one clock pass
    task automatic step(input string req);
        #1;
        check(req, "grant", int'(grant_o), exp_grant());
        for (int t = 0; t < 2; t++) begin
            check(req, $sformatf("level t%0d", t), int'(level_o[t]), m_lvl[t]);
            check(req, $sformatf("flush t%0d", t), int'(flush_o[t]), int'(m_flush[t]));
        end
        @(posedge clk_i);
        if (rst_ni) model_advance();
        @(negedge clk_i);
    endtask

    task automatic set_thr(input int t, input int l2, input int tlb, input int rob);
        l2_miss_i[t]  = MISS_W'(l2);
        tlb_miss_i[t] = MISS_W'(tlb);
        rob_occ_i[t]  = ROB_W'(rob);
    endtask

    initial begin
        for (int t = 0; t < 2; t++) begin
            m_lvl[t] = 0; m_dwell[t] = 0; m_flush[t] = 0;
        end
        m_cnt = 0;
        // R1: reset holds everything in NORMAL, even under congestion
        set_thr(0, 9, 9, 60);
        @(negedge clk_i);
        step("R1");
        step("R1");
        set_thr(0, 0, 0, 0);
        rst_ni = 1'b1;
        step("R1");

        // R7: equal levels alternate, then uneven patterns
        for (int i = 0; i < 6; i++) step("R7");
        pri_i[0] = 3'd5; pri_i[1] = 3'd2;
        for (int i = 0; i < 12; i++) step("R7");
        pri_i[0] = 3'd1; pri_i[1] = 3'd6;
        for (int i = 0; i < 16; i++) step("R7");

        // R2: miss-sum trigger on thread 0 (3+5 reaches 8); R5 priority drop
        pri_i[0] = 3'd4; pri_i[1] = 3'd2;
        set_thr(0, 3, 5, 0);
        step("R2");
        for (int i = 0; i < 4; i++) step("R5");
        // R4 STALL, then PURGE with one flush (R6), then HOLD; R8 slot moves
        for (int i = 0; i < 4; i++) step("R4 R8");
        step("R6");
        for (int i = 0; i < 6; i++) step("R6 R8");
        // R3: band between thresholds keeps HOLD
        set_thr(0, 2, 3, 25);
        for (int i = 0; i < 5; i++) step("R3");
        set_thr(0, 1, 1, 10);
        step("R3");
        step("R3");

        // R10: occupancy trigger on thread 1 only; R3 early release
        set_thr(1, 0, 0, 45);
        step("R10");
        set_thr(1, 0, 0, 30);
        for (int i = 0; i < 2; i++) step("R10");
        set_thr(1, 0, 0, 5);
        step("R3");
        step("R3");

        // R8: both threads blocked, then released
        dwell_lim_i = 8'd0;
        set_thr(0, 0, 0, 50);
        set_thr(1, 4, 4, 0);
        for (int i = 0; i < 8; i++) step("R8");
        set_thr(0, 0, 0, 0);
        set_thr(1, 0, 0, 0);
        step("R8");
        step("R8");

        // R9: shrink the pattern while the counter is high
        pri_i[0] = 3'd7; pri_i[1] = 3'd0;
        for (int i = 0; i < 20 && m_cnt != 5; i++) step("R7");
        pri_i[0] = 3'd3; pri_i[1] = 3'd3;
        step("R9");
        step("R9");
        step("R9");

        // mixed stimulus
        dwell_lim_i = 8'd2;
        for (int i = 0; i < 3000; i++) begin
            if (i % 8 == 0) begin
                pri_i[0] = 3'($urandom_range(0, 7));
                pri_i[1] = 3'($urandom_range(0, 7));
            end
            for (int t = 0; t < 2; t++)
                set_thr(t, $urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 60));
            step("R2 R3 R4 R6 R7 R8");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule